// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block turns a pair of host I/O resources into indirect accesses to the configuration registers of a fixed grid of device slots. One port holds a 32-bit address latch. Four byte-lane data ports follow it. The host first writes the latch with an enable bit and the bus, device, function and dword index fields. It then reads or writes one of the data ports. The block decodes the latch, selects a single slot and hands that slot a byte offset, an access length, the function number and the write data. On a read it returns the slot's answer.

The grid is `NUM_BUS` buses by `NUM_DEV` device slots. The flat slot index is `bus*NUM_DEV + dev`. A presence vector tells the block which slots are populated. Three kinds of data access are absorbed, and a read of any of them answers with all ones: an access while the enable bit is clear, an access outside the grid, and an access to an empty slot.

Host port encoding: `io_port_i[2]` = 0 selects the address latch, and the low two bits are then ignored. `io_port_i[2]` = 1 selects a data port, and `io_port_i[1:0]` gives the byte lane. The length code is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write to the latch port stores all 32 bits of `io_wdata_i`, whatever the length code. A later latch read returns that value unchanged, including bits 30:24.
- R2: After reset the latch reads as 0. Because the enable bit is then clear, a data port read returns 32'hFFFF_FFFF.
- R3: While latch bit 31 is 0, data port reads return 32'hFFFF_FFFF and data port writes raise no slot select.
- R4: Latch fields are bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2. The selected slot is `bus*NUM_DEV + dev`. A data access in the cycle right after a latch write uses the new latch value.
- R5: The slot offset `slot_off_o` equals {latch[7:2], io_port_i[1:0]}.
- R6: If bus >= `NUM_BUS` or device >= `NUM_DEV`, no slot is selected. A read of such an address returns 32'hFFFF_FFFF.
- R7: If the addressed slot's `slot_present_i` bit is 0, no slot is selected. A read of such an address returns 32'hFFFF_FFFF.
- R8: The function field does not affect which slot is selected. It is forwarded on `slot_func_o`.
- R9: The length code is forwarded on `slot_len_o`. A read that hits a slot returns the slot data zero-extended: only bits 7:0 for code 0, only bits 15:0 for code 1, all 32 bits for codes 2 and 3.
- R10: Each data access that hits a present slot raises exactly one bit of `slot_sel_o`, for the single cycle after the request. `slot_we_o` marks a write, and `slot_wdata_o` carries `io_wdata_i` unchanged.
- R11: Each read request (latch or data) produces `io_rvalid_o` for one cycle, with `io_rdata_o`, two rising edges after the edge that samples the request. Writes produce no response. Requests may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_valid_i | input | 1 | Host access request, one per cycle |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_port_i | input | 3 | Bit 2: 0 = address latch, 1 = data port; bits 1:0 = byte lane |
| io_len_i | input | 2 | Access length code (0 = 1 B, 1 = 2 B, 2/3 = 4 B) |
| io_wdata_i | input | 32 | Host write data |
| io_rdata_o | output | 32 | Read response data |
| io_rvalid_o | output | 1 | Read response strobe |
| slot_present_i | input | NUM_BUS*NUM_DEV | Slot populated flags, flat index |
| slot_sel_o | output | NUM_BUS*NUM_DEV | One-hot slot select pulse |
| slot_we_o | output | 1 | Selected access is a write |
| slot_off_o | output | 8 | Register byte offset |
| slot_func_o | output | 3 | Function number |
| slot_len_o | output | 2 | Access length code |
| slot_wdata_o | output | 32 | Write data to slot |
| slot_rdata_i | input | 32*NUM_BUS*NUM_DEV | Per-slot read data, slot i in bits 32*i+31:32*i |

## Verification
The bench models every slot so that its read word encodes the slot index, offset, function and length it was given. Each read therefore shows whether routing, offset forming and length masking are correct. The latch is loaded with a range of addresses:
- in-range hits on both buses, including the first and the last slot;
- a bus just past the grid, a device just past the grid, and all-ones fields;
- an empty slot;
- a valid address with the enable bit clear;
- the same slot under different function numbers.

Together these separate a wrong slot from a missing one, and a dropped access from a mis-routed one. Back-to-back requests, including a data access right after a latch write, show that responses stay in order and that the new latch value is used at once.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    RSP_NONE,
    RSP_LATCH,
    RSP_HIT,
    RSP_MISS
  } rsp_kind_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] dw_idx;
  } cfg_addr_t;

  function automatic logic [DW-1:0] len_mask(input logic [1:0] len);
    case (len)
      2'd0:    len_mask = 32'h0000_00FF;
      2'd1:    len_mask = 32'h0000_FFFF;
      default: len_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_dec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output cfg_addr_t     fld_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i;
  end

  assign q_o           = q;
  assign fld_o.en      = q[31];
  assign fld_o.bus     = q[23:16];
  assign fld_o.dev     = q[15:11];
  assign fld_o.func    = q[10:8];
  assign fld_o.dw_idx  = q[7:2];
endmodule

// File: rtl/cfg_slot_route.sv
module cfg_slot_route
  import cfg_dec_pkg::*;
#(
  parameter int unsigned NUM_BUS = 2,
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned NSLOT  = NUM_BUS * NUM_DEV
) (
  input  cfg_addr_t        fld_i,
  input  logic [NSLOT-1:0] present_i,
  output logic [NSLOT-1:0] sel_o,
  output logic             hit_o
);
  // Out-of-range bus/dev values never match any generated slot.
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      localparam int unsigned IDX = b * NUM_DEV + d;
      assign sel_o[IDX] = fld_i.en && present_i[IDX]
                       && (fld_i.bus == 8'(b)) && (fld_i.dev == 5'(d));
    end
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_dec_pkg::*;
#(
  parameter int unsigned NSLOT = 8
) (
  input  logic [NSLOT-1:0]    sel_i,
  input  logic [NSLOT*DW-1:0] rdata_i,
  input  logic [1:0]          len_i,
  output logic [DW-1:0]       rdata_o
);
  logic [DW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (sel_i[i]) acc = acc | rdata_i[i*DW +: DW];
    end
  end

  assign rdata_o = acc & len_mask(len_i);
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_dec_pkg::*;
#(
  parameter int unsigned NUM_BUS = 2,
  parameter int unsigned NUM_DEV = 4,
  localparam int unsigned NSLOT  = NUM_BUS * NUM_DEV
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                io_valid_i,
  input  logic                io_write_i,
  input  logic [2:0]          io_port_i,
  input  logic [1:0]          io_len_i,
  input  logic [DW-1:0]       io_wdata_i,
  output logic [DW-1:0]       io_rdata_o,
  output logic                io_rvalid_o,
  input  logic [NSLOT-1:0]    slot_present_i,
  output logic [NSLOT-1:0]    slot_sel_o,
  output logic                slot_we_o,
  output logic [7:0]          slot_off_o,
  output logic [2:0]          slot_func_o,
  output logic [1:0]          slot_len_o,
  output logic [DW-1:0]       slot_wdata_o,
  input  logic [NSLOT*DW-1:0] slot_rdata_i
);
  logic          req_lat, req_dat;
  logic [DW-1:0] latch_q;
  cfg_addr_t     fld;
  logic [NSLOT-1:0] sel_c;
  logic          hit_c;
  logic [DW-1:0] mux_rd;

  rsp_kind_e        kind_q;
  logic [NSLOT-1:0] sel_q;
  logic             we_q;
  logic [7:0]       off_q;
  logic [2:0]       func_q;
  logic [1:0]       len_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;

  assign req_lat = io_valid_i && !io_port_i[2];
  assign req_dat = io_valid_i &&  io_port_i[2];

  cfg_addr_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_lat && io_write_i),
    .wdata_i (io_wdata_i),
    .q_o     (latch_q),
    .fld_o   (fld)
  );

  cfg_slot_route #(
    .NUM_BUS (NUM_BUS),
    .NUM_DEV (NUM_DEV)
  ) u_route (
    .fld_i     (fld),
    .present_i (slot_present_i),
    .sel_o     (sel_c),
    .hit_o     (hit_c)
  );

  // Stage 1: slot access cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= RSP_NONE;
      sel_q   <= '0;
      we_q    <= 1'b0;
      off_q   <= '0;
      func_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else begin
      sel_q <= req_dat ? sel_c : '0;
      if (!io_valid_i || io_write_i) kind_q <= RSP_NONE;
      else if (!io_port_i[2])        kind_q <= RSP_LATCH;
      else if (hit_c)                kind_q <= RSP_HIT;
      else                           kind_q <= RSP_MISS;
      if (req_dat) begin
        we_q    <= io_write_i;
        off_q   <= {fld.dw_idx, io_port_i[1:0]};
        func_q  <= fld.func;
        len_q   <= io_len_i;
        wdata_q <= io_wdata_i;
      end
    end
  end

  cfg_read_mux #(
    .NSLOT (NSLOT)
  ) u_rmux (
    .sel_i   (sel_q),
    .rdata_i (slot_rdata_i),
    .len_i   (len_q),
    .rdata_o (mux_rd)
  );

  // Stage 2: host response.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= (kind_q != RSP_NONE);
      case (kind_q)
        RSP_LATCH: rdata_q <= latch_q;
        RSP_HIT:   rdata_q <= mux_rd;
        RSP_MISS:  rdata_q <= '1;
        default:   rdata_q <= rdata_q;
      endcase
    end
  end

  assign slot_sel_o   = sel_q;
  assign slot_we_o    = we_q;
  assign slot_off_o   = off_q;
  assign slot_func_o  = func_q;
  assign slot_len_o   = len_q;
  assign slot_wdata_o = wdata_q;
  assign io_rdata_o   = rdata_q;
  assign io_rvalid_o  = rvalid_q;
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
  parameter int unsigned NSLOT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_valid_i,
  input logic             io_write_i,
  input logic             port_dat_i,
  input logic             wdata_en_i,
  input logic [31:0]      io_rdata_o,
  input logic             io_rvalid_o,
  input logic [NSLOT-1:0] slot_present_i,
  input logic [NSLOT-1:0] slot_sel_o,
  input logic             slot_we_o
);
  logic en_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_sh <= 1'b0;
    else if (io_valid_i && io_write_i && !port_dat_i) en_sh <= wdata_en_i;
  end

  AST_DISABLED_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(io_valid_i && port_dat_i && !en_sh) |-> (slot_sel_o == '0)); // R3

  AST_MISS_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rvalid_o && $past(port_dat_i, 2) && ($past(slot_sel_o) == '0))
    |-> (io_rdata_o == 32'hFFFF_FFFF)); // R6

  AST_SEL_ONLY_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_o != '0) |-> ((slot_sel_o & $past(slot_present_i)) != '0)); // R7

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_sel_o)); // R10

  AST_SEL_NEEDS_DATA_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_o != '0) |-> $past(io_valid_i && port_dat_i)); // R10

  AST_WE_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_o != '0) |-> (slot_we_o == $past(io_write_i))); // R10

  AST_RVALID_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o == $past(io_valid_i && !io_write_i, 2)); // R11
endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .io_valid_i     (io_valid_i),
  .io_write_i     (io_write_i),
  .port_dat_i     (io_port_i[2]),
  .wdata_en_i     (io_wdata_i[31]),
  .io_rdata_o     (io_rdata_o),
  .io_rvalid_o    (io_rvalid_o),
  .slot_present_i (slot_present_i),
  .slot_sel_o     (slot_sel_o),
  .slot_we_o      (slot_we_o)
);

// File: tb/cfg_port_decoder_tb.sv
module cfg_port_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int ND = 4;
  localparam int NS = NB * ND;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0;
  logic [2:0] io_port = '0;
  logic [1:0] io_len = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic io_rvalid;
  logic [NS-1:0] present = 8'b1011_0111;
  logic [NS-1:0] sel;
  logic we;
  logic [7:0] off;
  logic [2:0] func;
  logic [1:0] len;
  logic [31:0] wdata;
  logic [NS*32-1:0] srd;

  int n_chk = 0, n_fail = 0, sel_cnt = 0, n_rd = 0, n_rsp = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [52:0] wexp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder #(.NUM_BUS(NB), .NUM_DEV(ND)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_valid_i(io_valid), .io_write_i(io_write),
    .io_port_i(io_port), .io_len_i(io_len), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_rvalid_o(io_rvalid), .slot_present_i(present),
    .slot_sel_o(sel), .slot_we_o(we), .slot_off_o(off), .slot_func_o(func),
    .slot_len_o(len), .slot_wdata_o(wdata), .slot_rdata_i(srd)
  );

  // Slot model: word encodes what the slot was given.
  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign srd[i*32 +: 32] = {6'b0, len, 5'b0, func, off, 8'h40 | 8'(i)};
  end

  function automatic logic [31:0] slot_word(int idx, logic [7:0] o, logic [1:0] l, logic [2:0] f);
    logic [31:0] w, m;
    w = {6'b0, l, 5'b0, f, o, 8'h40 | 8'(idx)};
    m = (l == 2'd0) ? 32'hFF : (l == 2'd1) ? 32'hFFFF : ONES;
    return w & m;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic w, input logic [2:0] p, input logic [1:0] l, input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = w; io_port = p; io_len = l; io_wdata = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] p, input logic [1:0] l, input logic [31:0] e, input string tag);
    put(1'b0, p, l, 32'h0);
    exp_q.push_back(e); tag_q.push_back(tag); n_rd++;
  endtask

  task automatic set_latch(input logic [31:0] v);
    put(1'b1, 3'b000, 2'd2, v);
  endtask

  task automatic wr_hit(input logic [2:0] p, input logic [1:0] l, input logic [31:0] d,
                        input int idx, input logic [7:0] o, input logic [2:0] f, input string tag);
    int base;
    base = sel_cnt;
    wexp_q.push_back({8'(1 << idx), o, l, f, d});
    put(1'b1, p, l, d);
    idle(3);
    chk(tag, sel_cnt - base, 1);
  endtask

  task automatic wr_drop(input logic [2:0] p, input string tag);
    int base;
    base = sel_cnt;
    put(1'b1, p, 2'd2, 32'hDEAD_BEEF);
    idle(3);
    chk(tag, sel_cnt - base, 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (io_rvalid) begin
        n_rsp++;
        if (exp_q.size() == 0) chk("R11 unexpected response", 1, 0);
        else chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
      end
      if (sel != '0) begin
        sel_cnt++;
        if (we) begin
          if (wexp_q.size() == 0) chk("R10 unexpected slot write", 1, 0);
          else chk("R10 slot write fields", {sel, off, len, func, wdata}, wexp_q.pop_front());
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL R11 watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(3'b000, 2'd2, 32'h0, "R2 latch after reset");
    rd(3'b100, 2'd2, ONES, "R2 data read after reset");
    idle(2);

    // Latch store and read back
    set_latch(32'h7FFF_FFFF);
    rd(3'b000, 2'd0, 32'h7FFF_FFFF, "R1 latch full word");
    set_latch(32'h8001_0A48);
    rd(3'b000, 2'd2, 32'h8001_0A48, "R1 latch readback");
    idle(2);

    // Hit bus1 dev1 (slot 5), func 2, dword 0x12
    rd(3'b100, 2'd2, slot_word(5, 8'h48, 2'd2, 3'd2), "R4 route slot5 4B");
    rd(3'b111, 2'd0, slot_word(5, 8'h4B, 2'd0, 3'd2), "R9 lane3 1B zero-extend");
    rd(3'b110, 2'd1, slot_word(5, 8'h4A, 2'd1, 3'd2), "R5 lane2 offset 2B");
    rd(3'b101, 2'd3, slot_word(5, 8'h49, 2'd3, 3'd2), "R9 len code 3 full word");
    idle(2);
    wr_hit(3'b101, 2'd0, 32'h1234_56AB, 5, 8'h49, 3'd2, "R10 write hit one pulse");

    // Out of range
    set_latch(32'h8002_0800);
    rd(3'b100, 2'd2, ONES, "R6 bus beyond grid");
    idle(1);
    wr_drop(3'b100, "R6 bus beyond grid write dropped");
    set_latch(32'h8000_2000);
    rd(3'b100, 2'd2, ONES, "R6 dev beyond grid");
    idle(1);
    wr_drop(3'b101, "R6 dev beyond grid write dropped");
    set_latch(32'h80FF_F8FC);
    rd(3'b111, 2'd0, ONES, "R6 all-ones fields");
    idle(1);

    // Empty slot 3
    set_latch(32'h8000_1800);
    rd(3'b100, 2'd2, ONES, "R7 empty slot read");
    idle(1);
    wr_drop(3'b100, "R7 empty slot write dropped");

    // Function ignored for selection
    set_latch(32'h8000_1704);
    rd(3'b100, 2'd2, slot_word(2, 8'h04, 2'd2, 3'd7), "R8 func7 slot2");
    idle(1);
    wr_hit(3'b110, 2'd1, 32'h0000_BEEF, 2, 8'h06, 3'd7, "R8 func7 write slot2");
    set_latch(32'h8000_1004);
    rd(3'b100, 2'd2, slot_word(2, 8'h04, 2'd2, 3'd0), "R8 func0 slot2");
    idle(1);

    // Disabled with valid fields
    set_latch(32'h0001_0A48);
    rd(3'b100, 2'd2, ONES, "R3 disabled read");
    idle(1);
    wr_drop(3'b111, "R3 disabled write dropped");

    // Boundary slots 0 and 7
    set_latch(32'h8000_0000);
    rd(3'b100, 2'd2, slot_word(0, 8'h00, 2'd2, 3'd0), "R4 slot0");
    set_latch(32'h8001_1800);
    rd(3'b111, 2'd1, slot_word(7, 8'h03, 2'd1, 3'd0), "R5 slot7 lane3 2B");
    idle(1);

    // Back-to-back, latch write then immediate data access
    set_latch(32'h8000_0800);
    rd(3'b100, 2'd2, slot_word(1, 8'h00, 2'd2, 3'd0), "R11 b2b a");
    rd(3'b101, 2'd2, slot_word(1, 8'h01, 2'd2, 3'd0), "R11 b2b b");
    rd(3'b000, 2'd2, 32'h8000_0800, "R11 b2b latch");
    rd(3'b110, 2'd0, slot_word(1, 8'h02, 2'd0, 3'd0), "R11 b2b c");
    set_latch(32'h8001_0000);
    rd(3'b100, 2'd2, slot_word(4, 8'h00, 2'd2, 3'd0), "R4 new latch used at once");
    idle(6);

    chk("R11 response count", n_rsp, n_rd);
    chk("R11 responses pending", exp_q.size(), 0);
    chk("R10 slot writes pending", wexp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule